// File: doc/BRIEF.md
# Byte-Addressed Load/Store Data Memory

This block is the data memory of a small 32-bit load/store core. It holds a parameterised number of bytes, and every byte has its own address. One combinational read port and one clocked write port share a single address input. A 3-bit access-control input carries the load/store funct3 code of the instruction. That code picks a byte, halfword or word access and, for loads, either sign or zero extension.

Halfword and word accesses are not trapped when misaligned. Their address is rounded down to the 2-byte or 4-byte boundary by clearing the low address bits. All sizes are served from the same byte array in little-endian order: the lowest address of an access holds the least significant byte. Codes that name no access return zero on a load and write nothing on a store. The byte count must be a power of two and a multiple of four, and addresses wrap modulo that count.

The block has no state machine. The decoder, the lane address generator and the load formatter are pure combinational stages, and the byte array is the only storage.

Top module: `ls_data_mem`

## Requirements
- R1: The array changes only at a rising clock edge while `mem_we` is 1. With `mem_we` at 0, a store code changes no byte.
- R2: Code 000 loads the single addressed byte and returns it sign-extended from bit 7 to 32 bits.
- R3: Code 100 loads the single addressed byte and returns it zero-extended to 32 bits.
- R4: Code 001 loads a halfword from the address with bit 0 cleared. The byte at base+0 goes to bits 7:0 and the byte at base+1 goes to bits 15:8. The result is sign-extended from bit 15.
- R5: Code 101 loads the same halfword as R4 and zero-extends it.
- R6: Code 010 loads a word from the address with bits 1:0 cleared. The byte at base+0 goes to bits 7:0 and the byte at base+3 goes to bits 31:24.
- R7: Code 000 with `mem_we` at 1 writes `mem_wdata[7:0]` to the exact address and leaves every other byte unchanged.
- R8: Code 001 with `mem_we` at 1 writes `mem_wdata[7:0]` to the halfword base and `mem_wdata[15:8]` to base+1. No other byte changes.
- R9: Code 010 with `mem_we` at 1 writes `mem_wdata` to base+0 through base+3 in little-endian order.
- R10: Codes 011, 110 and 111 return 0 on `mem_rdata`, and write nothing even when `mem_we` is 1.
- R11: `mem_rdata` follows `mem_addr` and `mem_ctl` in the same cycle. During a cycle that writes the addressed bytes, it shows the old contents, and it shows the new contents after the edge.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock; writes take effect on its rising edge |
| mem_addr | input | IDX_W (8) | Byte address, taken modulo the byte count |
| mem_we | input | 1 | Write enable |
| mem_wdata | input | 32 | Store data; low bytes are used for narrow stores |
| mem_ctl | input | 3 | Access code (funct3 encoding) |
| mem_rdata | output | 32 | Formatted load result |

## Verification
A load and a store can fall in the same cycle on overlapping bytes, because the read port is combinational and shares its address with the write port. The bench provokes this by holding a store on an address whose old contents are known. It samples `mem_rdata` before the edge, where the old value is expected, and samples it again after the edge with the store released, where the new bytes are expected. An unused store code in the same overlapping position must leave the following word read unchanged.

// File: rtl/ls_mem_pkg.sv
package ls_mem_pkg;

    localparam int LANES = 4;
    localparam int LANE_W = 8;
    localparam int WORD_W = LANES * LANE_W;

    typedef enum logic [1:0] {
        SZ_BYTE = 2'd0,
        SZ_HALF = 2'd1,
        SZ_WORD = 2'd2
    } acc_size_t;

    localparam logic [2:0] CTL_B  = 3'b000;
    localparam logic [2:0] CTL_H  = 3'b001;
    localparam logic [2:0] CTL_W  = 3'b010;
    localparam logic [2:0] CTL_BU = 3'b100;
    localparam logic [2:0] CTL_HU = 3'b101;

endpackage

// File: rtl/ls_ctl_decode.sv
module ls_ctl_decode
    import ls_mem_pkg::*;
(
    input  logic [2:0] ctl,
    output acc_size_t  size,
    output logic       zext,
    output logic       valid
);

    always_comb begin
        size  = SZ_BYTE;
        zext  = 1'b0;
        valid = 1'b1;
        unique case (ctl)
            CTL_B:   size = SZ_BYTE;
            CTL_H:   size = SZ_HALF;
            CTL_W:   size = SZ_WORD;
            CTL_BU: begin
                size = SZ_BYTE;
                zext = 1'b1;
            end
            CTL_HU: begin
                size = SZ_HALF;
                zext = 1'b1;
            end
            default: valid = 1'b0;
        endcase
    end

endmodule

// File: rtl/ls_lane_addr.sv
module ls_lane_addr
    import ls_mem_pkg::*;
#(
    parameter int IDX_W = 8
) (
    input  logic [IDX_W-1:0]            addr,
    input  acc_size_t                   size,
    output logic [LANES-1:0][IDX_W-1:0] lane_addr,
    output logic [LANES-1:0]            lane_mask
);

    logic [IDX_W-1:0] base;

    always_comb begin
        unique case (size)
            SZ_WORD: base = {addr[IDX_W-1:2], 2'b00};
            SZ_HALF: base = {addr[IDX_W-1:1], 1'b0};
            default: base = addr;
        endcase
    end

    always_comb begin
        unique case (size)
            SZ_WORD: lane_mask = 4'b1111;
            SZ_HALF: lane_mask = 4'b0011;
            default: lane_mask = 4'b0001;
        endcase
    end

    for (genvar k = 0; k < LANES; k++) begin : g_lane
        assign lane_addr[k] = base + IDX_W'(k);
    end

endmodule

// File: rtl/ls_load_fmt.sv
module ls_load_fmt
    import ls_mem_pkg::*;
(
    input  logic [LANES-1:0][LANE_W-1:0] bytes_in,
    input  acc_size_t                    size,
    input  logic                         zext,
    input  logic                         valid,
    output logic [WORD_W-1:0]            result
);

    logic fill_b;
    logic fill_h;

    assign fill_b = ~zext & bytes_in[0][LANE_W-1];
    assign fill_h = ~zext & bytes_in[1][LANE_W-1];

    always_comb begin
        result = '0;
        if (valid) begin
            unique case (size)
                SZ_WORD: result = bytes_in;
                SZ_HALF: result = {{(WORD_W-2*LANE_W){fill_h}}, bytes_in[1], bytes_in[0]};
                default: result = {{(WORD_W-LANE_W){fill_b}}, bytes_in[0]};
            endcase
        end
    end

endmodule

// File: rtl/ls_data_mem.sv
module ls_data_mem
    import ls_mem_pkg::*;
#(
    parameter int MEM_BYTES = 256,
    localparam int IDX_W = $clog2(MEM_BYTES)
) (
    input  logic              clk,
    input  logic [IDX_W-1:0]  mem_addr,
    input  logic              mem_we,
    input  logic [WORD_W-1:0] mem_wdata,
    input  logic [2:0]        mem_ctl,
    output logic [WORD_W-1:0] mem_rdata
);

    acc_size_t                   size;
    logic                        zext;
    logic                        valid;
    logic [LANES-1:0][IDX_W-1:0] lane_addr;
    logic [LANES-1:0]            lane_mask;
    logic [LANES-1:0][LANE_W-1:0] rd_bytes;
    logic [LANES-1:0][LANE_W-1:0] wr_bytes;
    logic [LANE_W-1:0]           store [MEM_BYTES];

    ls_ctl_decode u_dec (
        .ctl   (mem_ctl),
        .size  (size),
        .zext  (zext),
        .valid (valid)
    );

    ls_lane_addr #(.IDX_W(IDX_W)) u_lanes (
        .addr      (mem_addr),
        .size      (size),
        .lane_addr (lane_addr),
        .lane_mask (lane_mask)
    );

    assign wr_bytes = mem_wdata;

    for (genvar k = 0; k < LANES; k++) begin : g_rd
        assign rd_bytes[k] = store[lane_addr[k]];
    end

    always_ff @(posedge clk) begin
        for (int k = 0; k < LANES; k++) begin
            if (mem_we && valid && lane_mask[k]) begin
                store[lane_addr[k]] <= wr_bytes[k];
            end
        end
    end

    ls_load_fmt u_fmt (
        .bytes_in (rd_bytes),
        .size     (size),
        .zext     (zext),
        .valid    (valid),
        .result   (mem_rdata)
    );

    logic chk_live = 1'b0;
    always_ff @(posedge clk) chk_live <= 1'b1;

    p_rd_hold_r1: assert property (@(posedge clk) disable iff (!chk_live)
        ($past(!mem_we) && $stable(mem_addr) && $stable(mem_ctl)) |-> $stable(mem_rdata));

    p_lb_sext_r2: assert property (@(posedge clk) disable iff (!chk_live)
        (mem_ctl == CTL_B) |-> (mem_rdata[31:8] == {24{mem_rdata[7]}}));

    p_lbu_zero_r3: assert property (@(posedge clk) disable iff (!chk_live)
        (mem_ctl == CTL_BU) |-> (mem_rdata[31:8] == 24'd0));

    p_lhu_zero_r5: assert property (@(posedge clk) disable iff (!chk_live)
        (mem_ctl == CTL_HU) |-> (mem_rdata[31:16] == 16'd0));

    p_sw_back_r9: assert property (@(posedge clk) disable iff (!chk_live)
        ($past(mem_we && mem_ctl == CTL_W) && $stable(mem_addr) && $stable(mem_ctl))
            |-> (mem_rdata == $past(mem_wdata)));

    p_bad_zero_r10: assert property (@(posedge clk) disable iff (!chk_live)
        (mem_ctl inside {3'b011, 3'b110, 3'b111}) |-> (mem_rdata == '0));

endmodule

// File: tb/ls_data_mem_bench.sv
`timescale 1ns/1ps
module ls_data_mem_bench;

    typedef struct packed {
        logic        we;
        logic [2:0]  ctl;
        logic [7:0]  addr;
        logic [31:0] wd;
        logic        chk;
        logic [31:0] exp;
        logic [3:0]  req;
    } vec_t;

    localparam int NV = 22;
    localparam vec_t TBL [NV] = '{
        '{1'b1, 3'b010, 8'h10, 32'h8899AABB, 1'b0, 32'h0, 4'd9},
        '{1'b0, 3'b010, 8'h13, 32'h0,        1'b1, 32'h8899AABB, 4'd6},  // R6 rounding
        '{1'b0, 3'b000, 8'h10, 32'h0,        1'b1, 32'hFFFFFFBB, 4'd2},  // R2
        '{1'b0, 3'b100, 8'h11, 32'h0,        1'b1, 32'h000000AA, 4'd3},  // R3
        '{1'b0, 3'b001, 8'h13, 32'h0,        1'b1, 32'hFFFF8899, 4'd4},  // R4 negative
        '{1'b0, 3'b101, 8'h11, 32'h0,        1'b1, 32'h0000AABB, 4'd5},  // R5
        '{1'b0, 3'b101, 8'h12, 32'h0,        1'b1, 32'h00008899, 4'd5},  // R5 high bit set
        '{1'b1, 3'b000, 8'h11, 32'h12345678, 1'b1, 32'hFFFFFFAA, 4'd11}, // R11 old value
        '{1'b0, 3'b010, 8'h10, 32'h0,        1'b1, 32'h889978BB, 4'd7},  // R7
        '{1'b1, 3'b010, 8'h14, 32'h11223344, 1'b0, 32'h0, 4'd9},
        '{1'b1, 3'b001, 8'h15, 32'hCAFE7F01, 1'b0, 32'h0, 4'd8},
        '{1'b0, 3'b010, 8'h16, 32'h0,        1'b1, 32'h11227F01, 4'd8},  // R8
        '{1'b0, 3'b001, 8'h14, 32'h0,        1'b1, 32'h00007F01, 4'd4},  // R4 positive
        '{1'b0, 3'b000, 8'h14, 32'hFFFFFFFF, 1'b1, 32'h00000001, 4'd1},
        '{1'b0, 3'b010, 8'h14, 32'h0,        1'b1, 32'h11227F01, 4'd1},  // R1 no write
        '{1'b1, 3'b011, 8'h14, 32'hFFFFFFFF, 1'b1, 32'h00000000, 4'd10}, // R10 load zero
        '{1'b1, 3'b110, 8'h14, 32'hFFFFFFFF, 1'b1, 32'h00000000, 4'd10},
        '{1'b1, 3'b111, 8'h15, 32'hFFFFFFFF, 1'b1, 32'h00000000, 4'd10},
        '{1'b0, 3'b010, 8'h14, 32'h0,        1'b1, 32'h11227F01, 4'd10}, // R10 no write
        '{1'b1, 3'b010, 8'hFE, 32'hDEADBEEF, 1'b0, 32'h0, 4'd9},
        '{1'b0, 3'b010, 8'hFC, 32'h0,        1'b1, 32'hDEADBEEF, 4'd9},  // R9 top word
        '{1'b0, 3'b000, 8'hFF, 32'h0,        1'b1, 32'hFFFFFFDE, 4'd9}   // R9 MSB at base+3
    };

    logic        clk = 1'b0;
    logic [7:0]  mem_addr = '0;
    logic        mem_we = 1'b0;
    logic [31:0] mem_wdata = '0;
    logic [2:0]  mem_ctl = 3'b000;
    logic [31:0] mem_rdata;
    int checks = 0;
    int errors = 0;
    logic done = 1'b0;

    always #2.5 clk = ~clk;

    ls_data_mem u_ls_data_mem (
        .clk       (clk),
        .mem_addr  (mem_addr),
        .mem_we    (mem_we),
        .mem_wdata (mem_wdata),
        .mem_ctl   (mem_ctl),
        .mem_rdata (mem_rdata)
    );

    task automatic check(input string req, input logic [31:0] exp);
        checks++;
        if (mem_rdata !== exp) begin
            errors++;
            $display("FAIL %s: got %08h expected %08h", req, mem_rdata, exp);
        end
    endtask

    task automatic drive(input logic we, input logic [2:0] ctl, input logic [7:0] a,
                         input logic [31:0] wd);
        @(negedge clk);
        mem_we = we;
        mem_ctl = ctl;
        mem_addr = a;
        mem_wdata = wd;
        #1;
    endtask

    initial begin
        for (int i = 0; i < NV; i++) begin
            drive(TBL[i].we, TBL[i].ctl, TBL[i].addr, TBL[i].wd);
            if (TBL[i].chk) check($sformatf("R%0d", TBL[i].req), TBL[i].exp);
        end
        // R11 overlap: store word, read same word before and after the edge
        drive(1'b0, 3'b010, 8'h20, 32'h0);
        drive(1'b1, 3'b010, 8'h20, 32'h01020304);
        drive(1'b1, 3'b010, 8'h20, 32'hA5A55A5A);
        check("R11", 32'h01020304);
        drive(1'b0, 3'b010, 8'h21, 32'h0);
        check("R11", 32'hA5A55A5A);
        // R7 byte store at odd address leaves neighbours
        drive(1'b1, 3'b000, 8'h23, 32'hFFFFFF00);
        drive(1'b0, 3'b010, 8'h20, 32'h0);
        check("R7", 32'h00A55A5A);
        // R1: write enable low with store code
        drive(1'b0, 3'b001, 8'h20, 32'h0000FFFF);
        drive(1'b0, 3'b010, 8'h20, 32'h0);
        check("R1", 32'h00A55A5A);
        done = 1'b1;
        $display("Simulation finished: %0d checks, %0d errors", checks, errors);
        $finish;
    end

    initial begin
        #(200000 * 5);
        if (!done) begin
            errors++;
            $display("FAIL watchdog: got timeout expected completion");
            $display("Simulation finished: %0d checks, %0d errors", checks, errors);
            $finish;
        end
    end

endmodule